// File: doc/BRIEF.md
# LCD Pixel Unpacking Serializer

This block sits between the frame-buffer fetch queues of a colour LCD controller and the pixel pipeline that follows. It takes 32-bit words from the read side of a DMA FIFO and breaks each one into a stream of pixel values. A depth setting picks how many pixels each word holds: one, two, four, eight, twelve or sixteen bits each. Pixels leave one at a time through a valid/ready handshake, in the order they appear in the frame.

Shallow depths of 8 bits or less produce palette indices. The 12- and 16-bit depths bypass the palette and drive the panel data directly. When two panels share the controller, the block fetches words from an upper-panel queue and a lower-panel queue in turn. It marks every pixel with the panel it belongs to. A change of depth or panel arrangement takes effect at the next word. Any pixels left in the current word are thrown away.

Top module: `lcd_pix_serializer`

## Requirements
- R1: With depth code 0 (1 bit per pixel), each word yields 32 pixels. The first pixel is bit 0 and each later pixel is the next higher bit.
- R2: Depth code 1 (2 bpp) yields 16 pixels per word, code 2 (4 bpp) yields 8, and code 3 (8 bpp) yields 4. In each case the least significant field leaves first and the fields follow in ascending bit order.
- R3: Depth code 5 (16 bpp) yields 2 pixels per word, first bits 15:0 and then bits 31:16. Codes 6 and 7 behave as code 5.
- R4: Depth code 4 (12 bpp) yields 2 pixels per word, taken from bits 11:0 and then bits 27:16. Bits 15:12 and 31:28 never reach the output, and the value is zero-extended to 16 bits.
- R5: For codes 0 to 3, `pix_pal_en` is 1, the field is zero-extended on `pix_index`, and `pix_direct` is 0. For codes 4 to 7, `pix_pal_en` is 0, the value appears on `pix_direct`, and `pix_index` is 0.
- R6: A source ready is raised only while no word is held. A new word is fetched only after the last pixel of the current word has been accepted, so no pixel is lost or repeated.
- R7: While `pix_valid` is high and `pix_ready` is low, every pixel output holds its value until the pixel is accepted, unless the mode changes.
- R8: With `cfg_dual` = 1, words come alternately from the upper queue and then the lower queue, with the upper queue served first. `pix_panel` is 0 for upper-queue pixels and 1 for lower-queue pixels. With `cfg_dual` = 0, only the upper queue is read, `lo_ready` stays 0 and `pix_panel` is 0.
- R9: In the cycle in which `cfg_bpp` or `cfg_dual` differs from its value in the previous cycle, no pixel is offered and no word is fetched. Any partly consumed word is discarded, the next word is decoded with the new mode, and the dual-panel sequence restarts at the upper queue.
- R10: After reset no pixel is offered and the upper queue is the one being requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bpp | input | 3 | Depth code: 0=1, 1=2, 2=4, 3=8, 4=12, 5..7=16 bits per pixel |
| cfg_dual | input | 1 | 1 = two panels, fetch upper and lower queues alternately |
| up_valid | input | 1 | Upper queue has a word |
| up_data | input | 32 | Upper queue word |
| up_ready | output | 1 | Upper queue word taken this cycle when valid |
| lo_valid | input | 1 | Lower queue has a word |
| lo_data | input | 32 | Lower queue word |
| lo_ready | output | 1 | Lower queue word taken this cycle when valid |
| pix_valid | output | 1 | A pixel is offered |
| pix_ready | input | 1 | Downstream accepts the offered pixel |
| pix_pal_en | output | 1 | 1 = pixel is a palette index, 0 = direct value |
| pix_index | output | 8 | Palette index, zero-extended |
| pix_direct | output | 16 | Direct panel value, zero-extended |
| pix_panel | output | 1 | 0 = upper panel, 1 = lower panel |

## Verification
The delicate overlap is a mode change that arrives in the same cycle as a pixel handshake or a pending word fetch. At that moment the block has to discard the held word rather than advance it, and it must not take a new word. The bench changes the mode right after a chosen number of accepted pixels, with both queues holding data. It checks that the cycle of the change offers no pixel. It then checks that the next pixels are decoded from a fresh word at the new depth, and that in dual-panel runs this fresh word comes from the upper queue. Backpressure and gaps in the source words are applied throughout, and a reference expansion of every fetched word judges the pixel sequence.

// File: rtl/lcd_unpack_pkg.sv
package lcd_unpack_pkg;

    localparam int WORD_W = 32;
    localparam int PIX_W  = 16;
    localparam int IDX_W  = 8;
    localparam int CNT_W  = $clog2(WORD_W);
    localparam int SH_W   = $clog2(WORD_W) + 4;

    typedef enum logic [2:0] {
        DEPTH_1  = 3'd0,
        DEPTH_2  = 3'd1,
        DEPTH_4  = 3'd2,
        DEPTH_8  = 3'd3,
        DEPTH_12 = 3'd4,
        DEPTH_16 = 3'd5
    } depth_e;

    typedef struct packed {
        logic [2:0] depth;
        logic       dual;
    } mode_t;

    typedef struct packed {
        logic             pal;
        logic [IDX_W-1:0] index;
        logic [PIX_W-1:0] direct;
        logic             panel;
    } pixel_t;

    function automatic depth_e norm_depth(input logic [2:0] code);
        depth_e d;
        case (code)
            3'd0:    d = DEPTH_1;
            3'd1:    d = DEPTH_2;
            3'd2:    d = DEPTH_4;
            3'd3:    d = DEPTH_8;
            3'd4:    d = DEPTH_12;
            default: d = DEPTH_16;
        endcase
        return d;
    endfunction

    // Index of the final field inside a word.
    function automatic logic [CNT_W-1:0] last_field(input depth_e d);
        logic [CNT_W-1:0] n;
        case (d)
            DEPTH_1:  n = CNT_W'(WORD_W - 1);
            DEPTH_2:  n = CNT_W'(WORD_W / 2 - 1);
            DEPTH_4:  n = CNT_W'(WORD_W / 4 - 1);
            DEPTH_8:  n = CNT_W'(WORD_W / 8 - 1);
            default:  n = CNT_W'(WORD_W / 16 - 1);
        endcase
        return n;
    endfunction

    // log2 of the slot pitch in bits.
    function automatic logic [2:0] slot_log2(input depth_e d);
        logic [2:0] s;
        case (d)
            DEPTH_1:  s = 3'd0;
            DEPTH_2:  s = 3'd1;
            DEPTH_4:  s = 3'd2;
            DEPTH_8:  s = 3'd3;
            default:  s = 3'd4;
        endcase
        return s;
    endfunction

    // Bits of each slot that carry pixel data.
    function automatic logic [PIX_W-1:0] value_mask(input depth_e d);
        logic [PIX_W-1:0] m;
        case (d)
            DEPTH_1:  m = PIX_W'(16'h0001);
            DEPTH_2:  m = PIX_W'(16'h0003);
            DEPTH_4:  m = PIX_W'(16'h000F);
            DEPTH_8:  m = PIX_W'(16'h00FF);
            DEPTH_12: m = PIX_W'(16'h0FFF);
            default:  m = PIX_W'(16'hFFFF);
        endcase
        return m;
    endfunction

    function automatic logic uses_palette(input depth_e d);
        return (d == DEPTH_1) || (d == DEPTH_2) || (d == DEPTH_4) || (d == DEPTH_8);
    endfunction

endpackage

// File: rtl/lcd_src_sel.sv
module lcd_src_sel
    import lcd_unpack_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dual,
    input  logic         restart,
    input  logic         want,
    input  logic         up_valid,
    input  logic [W-1:0] up_data,
    input  logic         lo_valid,
    input  logic [W-1:0] lo_data,
    output logic         up_ready,
    output logic         lo_ready,
    output logic         take,
    output logic         take_lower,
    output logic [W-1:0] take_data
);

    logic turn_lower_q;
    logic sel_lower;

    assign sel_lower  = dual && turn_lower_q;
    assign up_ready   = want && !sel_lower;
    assign lo_ready   = want && sel_lower;
    assign take       = sel_lower ? (want && lo_valid) : (want && up_valid);
    assign take_lower = sel_lower;
    assign take_data  = sel_lower ? lo_data : up_data;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            turn_lower_q <= 1'b0;
        end else if (take && dual) begin
            turn_lower_q <= !turn_lower_q;
        end
    end

endmodule

// File: rtl/lcd_field_extract.sv
module lcd_field_extract
    import lcd_unpack_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int PW = PIX_W,
    parameter int CW = CNT_W,
    parameter int SW = SH_W
) (
    input  logic [W-1:0]  word,
    input  depth_e        depth,
    input  logic [CW-1:0] slot,
    output logic [PW-1:0] value
);

    logic [SW-1:0] shamt;

    always_comb begin
        shamt = SW'(slot) << slot_log2(depth);
        value = PW'(word >> shamt) & PW'(value_mask(depth));
    end

endmodule

// File: rtl/lcd_pix_route.sv
module lcd_pix_route
    import lcd_unpack_pkg::*;
#(
    parameter int PW = PIX_W,
    parameter int IW = IDX_W
) (
    input  logic [PW-1:0] value,
    input  depth_e        depth,
    input  logic          panel,
    output pixel_t        pix
);

    always_comb begin
        pix.pal    = uses_palette(depth);
        pix.panel  = panel;
        pix.index  = '0;
        pix.direct = '0;
        if (pix.pal) begin
            pix.index = value[IW-1:0];
        end else begin
            pix.direct = value;
        end
    end

endmodule

// File: rtl/lcd_pix_serializer.sv
module lcd_pix_serializer
    import lcd_unpack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cfg_bpp,
    input  logic              cfg_dual,
    input  logic              up_valid,
    input  logic [WORD_W-1:0] up_data,
    output logic              up_ready,
    input  logic              lo_valid,
    input  logic [WORD_W-1:0] lo_data,
    output logic              lo_ready,
    output logic              pix_valid,
    input  logic              pix_ready,
    output logic              pix_pal_en,
    output logic [IDX_W-1:0]  pix_index,
    output logic [PIX_W-1:0]  pix_direct,
    output logic              pix_panel
);

    mode_t             cfg_now;
    mode_t             cfg_seen_q;
    logic              mode_moved;
    logic              holding_q;
    logic [WORD_W-1:0] word_q;
    logic [CNT_W-1:0]  slot_q;
    depth_e            act_depth_q;
    logic              panel_q;

    logic              want;
    logic              take;
    logic              take_lower;
    logic [WORD_W-1:0] take_data;
    logic [PIX_W-1:0]  value;
    pixel_t            pix;
    logic              pix_fire;
    logic              at_last;

    assign cfg_now    = '{depth: cfg_bpp, dual: cfg_dual};
    assign mode_moved = (cfg_now != cfg_seen_q);
    assign want       = !holding_q && !mode_moved;
    assign pix_valid  = holding_q && !mode_moved;
    assign pix_fire   = pix_valid && pix_ready;
    assign at_last    = (slot_q == last_field(act_depth_q));

    lcd_src_sel #(.W(WORD_W)) src_i (
        .clk        (clk),
        .rst        (rst),
        .dual       (cfg_dual),
        .restart    (mode_moved),
        .want       (want),
        .up_valid   (up_valid),
        .up_data    (up_data),
        .lo_valid   (lo_valid),
        .lo_data    (lo_data),
        .up_ready   (up_ready),
        .lo_ready   (lo_ready),
        .take       (take),
        .take_lower (take_lower),
        .take_data  (take_data)
    );

    lcd_field_extract #(.W(WORD_W), .PW(PIX_W), .CW(CNT_W), .SW(SH_W)) ext_i (
        .word  (word_q),
        .depth (act_depth_q),
        .slot  (slot_q),
        .value (value)
    );

    lcd_pix_route #(.PW(PIX_W), .IW(IDX_W)) route_i (
        .value (value),
        .depth (act_depth_q),
        .panel (panel_q),
        .pix   (pix)
    );

    assign pix_pal_en = pix.pal;
    assign pix_index  = pix.index;
    assign pix_direct = pix.direct;
    assign pix_panel  = pix.panel;

    always_ff @(posedge clk) begin
        cfg_seen_q <= cfg_now;
        if (rst) begin
            holding_q   <= 1'b0;
            word_q      <= '0;
            slot_q      <= '0;
            act_depth_q <= DEPTH_1;
            panel_q     <= 1'b0;
        end else if (mode_moved) begin
            holding_q <= 1'b0;
        end else if (take) begin
            holding_q   <= 1'b1;
            word_q      <= take_data;
            slot_q      <= '0;
            act_depth_q <= norm_depth(cfg_bpp);
            panel_q     <= take_lower && cfg_dual;
        end else if (pix_fire) begin
            if (at_last) begin
                holding_q <= 1'b0;
            end else begin
                slot_q <= slot_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lcd_pix_serializer_chk.sv
module lcd_pix_serializer_chk
    import lcd_unpack_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [2:0]        cfg_bpp,
    input logic              cfg_dual,
    input logic              up_ready,
    input logic              lo_ready,
    input logic              pix_valid,
    input logic              pix_ready,
    input logic              pix_pal_en,
    input logic [IDX_W-1:0]  pix_index,
    input logic [PIX_W-1:0]  pix_direct,
    input logic              pix_panel
);

    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (rst)
        !(up_ready && lo_ready)); // R8

    AST_SINGLE_NO_LOWER: assert property (@(posedge clk) disable iff (rst)
        !cfg_dual |-> !lo_ready); // R8

    AST_SINGLE_PANEL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && !cfg_dual) |-> !pix_panel); // R8

    AST_NO_FETCH_WHILE_HELD: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> !(up_ready || lo_ready)); // R6

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && !pix_ready) |=>
            ((cfg_bpp != $past(cfg_bpp)) || (cfg_dual != $past(cfg_dual)) ||
             (pix_valid && $stable(pix_index) && $stable(pix_direct) &&
              $stable(pix_panel) && $stable(pix_pal_en)))); // R7

    AST_PALETTE_ROUTE: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && cfg_bpp < 3'd4) |-> (pix_pal_en && pix_direct == '0)); // R5

    AST_DIRECT_ROUTE: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && cfg_bpp >= 3'd4) |-> (!pix_pal_en && pix_index == '0)); // R5

    AST_TWELVE_TOP_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && cfg_bpp == 3'd4) |-> (pix_direct[15:12] == 4'h0)); // R4

    AST_ONE_BIT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && cfg_bpp == 3'd0) |-> (pix_index[7:1] == '0)); // R1

    AST_CHANGE_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((cfg_bpp != $past(cfg_bpp)) || (cfg_dual != $past(cfg_dual))) |->
            (!pix_valid && !up_ready && !lo_ready)); // R9

endmodule

bind lcd_pix_serializer lcd_pix_serializer_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .cfg_bpp    (cfg_bpp),
    .cfg_dual   (cfg_dual),
    .up_ready   (up_ready),
    .lo_ready   (lo_ready),
    .pix_valid  (pix_valid),
    .pix_ready  (pix_ready),
    .pix_pal_en (pix_pal_en),
    .pix_index  (pix_index),
    .pix_direct (pix_direct),
    .pix_panel  (pix_panel)
);

// File: tb/lcd_pix_serializer_tb_top.sv
module lcd_pix_serializer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    typedef struct packed {
        logic        pal;
        logic [7:0]  idx;
        logic [15:0] dir;
        logic        pan;
    } exp_pix_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cfg_bpp = 3'd0;
    logic        cfg_dual = 1'b0;
    logic        up_valid = 1'b0;
    logic [31:0] up_data = '0;
    logic        up_ready;
    logic        lo_valid = 1'b0;
    logic [31:0] lo_data = '0;
    logic        lo_ready;
    logic        pix_valid;
    logic        pix_ready = 1'b0;
    logic        pix_pal_en;
    logic [7:0]  pix_index;
    logic [15:0] pix_direct;
    logic        pix_panel;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lcd_pix_serializer dut_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_bpp    (cfg_bpp),
        .cfg_dual   (cfg_dual),
        .up_valid   (up_valid),
        .up_data    (up_data),
        .up_ready   (up_ready),
        .lo_valid   (lo_valid),
        .lo_data    (lo_data),
        .lo_ready   (lo_ready),
        .pix_valid  (pix_valid),
        .pix_ready  (pix_ready),
        .pix_pal_en (pix_pal_en),
        .pix_index  (pix_index),
        .pix_direct (pix_direct),
        .pix_panel  (pix_panel)
    );

    function automatic string req_of(input logic [2:0] b);
        if (b == 3'd0) return "R1";
        if (b <= 3'd3) return "R2";
        if (b == 3'd4) return "R4";
        return "R3";
    endfunction

    function automatic int count_of(input logic [2:0] b);
        case (b)
            3'd0: return 32;
            3'd1: return 16;
            3'd2: return 8;
            3'd3: return 4;
            default: return 2;
        endcase
    endfunction

    // Expected pixel k of a word, from the requirements.
    function automatic exp_pix_t expect_pix(input logic [31:0] w, input logic [2:0] b,
                                            input int k, input logic pan);
        exp_pix_t e;
        logic [31:0] v;
        int width;
        width = 32 / count_of(b);
        v = w >> (k * width);
        e.pan = pan;
        e.idx = '0;
        e.dir = '0;
        if (b <= 3'd3) begin
            e.pal = 1'b1;
            e.idx = 8'(v & ((32'd1 << width) - 1));
        end else begin
            e.pal = 1'b0;
            e.dir = (b == 3'd4) ? {4'h0, v[11:0]} : v[15:0];
        end
        return e;
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic dual);
        cfg_dual = dual;
        cfg_bpp  = 3'd0;
        up_valid = 1'b0;
        lo_valid = 1'b0;
        pix_ready = 1'b0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(pix_valid == 1'b0, "R10", "pix_valid after reset", 32'(pix_valid), 0);
        check(up_ready == 1'b1, "R10", "up_ready after reset", 32'(up_ready), 1);
        check(lo_ready == 1'b0, "R10", "lo_ready after reset", 32'(lo_ready), 0);
    endtask

    // Feeds nw words per active queue and checks every pixel; optionally changes
    // the mode after chg_at accepted pixels.
    task automatic run_stream(input logic [2:0] b1, input logic d1, input int nw,
                              input int chg_at, input logic [2:0] b2, input logic d2,
                              input int vgap, input int rgap, input logic [31:0] seed);
        logic [31:0] upq[$];
        logic [31:0] loq[$];
        exp_pix_t    expq[$];
        logic [2:0]  cur_b;
        logic        cur_d;
        logic        exp_lower;
        logic        changed;
        logic        chg_now;
        logic        stalled;
        exp_pix_t    held;
        exp_pix_t    got;
        int          accepted;
        int          total_exp;
        int          viol_fetch;
        int          viol_hold;
        for (int i = 0; i < nw; i++) begin
            upq.push_back(32'h9E3779B9 * (i + 1) + seed);
            if (d1) loq.push_back(32'h7F4A7C15 * (i + 3) ^ seed);
        end
        cfg_bpp = b1;
        cfg_dual = d1;
        cur_b = b1;
        cur_d = d1;
        exp_lower = 1'b0;
        changed = 1'b0;
        stalled = 1'b0;
        held = '0;
        accepted = 0;
        total_exp = 0;
        viol_fetch = 0;
        viol_hold = 0;
        for (int cyc = 0; cyc < 20000; cyc++) begin
            @(negedge clk);
            chg_now = 1'b0;
            if (chg_at >= 0 && !changed && accepted == chg_at) begin
                cfg_bpp = b2;
                cfg_dual = d2;
                cur_b = b2;
                cur_d = d2;
                changed = 1'b1;
                chg_now = 1'b1;
                expq.delete();
                exp_lower = 1'b0;
            end
            up_valid = (upq.size() > 0) && (vgap == 0 || (cyc % vgap) != 1);
            up_data  = (upq.size() > 0) ? upq[0] : 32'hDEAD_BEEF;
            lo_valid = (loq.size() > 0) && (vgap == 0 || (cyc % vgap) != 4);
            lo_data  = (loq.size() > 0) ? loq[0] : 32'hDEAD_BEEF;
            pix_ready = (rgap == 0) || ((cyc % rgap) != 2);
            #1;
            got = '{pal: pix_pal_en, idx: pix_index, dir: pix_direct, pan: pix_panel};
            if (chg_now) begin
                check(!pix_valid && !up_ready && !lo_ready, "R9",
                      "quiet cycle on mode change", {pix_valid, up_ready, lo_ready}, 0);
            end else if (stalled) begin
                if (!pix_valid || got != held) viol_hold++;
            end
            if (pix_valid && (up_ready || lo_ready)) viol_fetch++;
            if (pix_valid && pix_ready) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R6", "pixel with nothing expected", 32'(got), 0);
                end else begin
                    check(got[25:1] == expq[0][25:1], req_of(cur_b),
                          (got.pal != expq[0].pal) ? "pixel value / R5 routing" : "pixel value",
                          32'(got[25:1]), 32'(expq[0][25:1]));
                    if (cur_d) begin
                        check(got.pan == expq[0].pan, "R8", "panel flag",
                              32'(got.pan), 32'(expq[0].pan));
                    end else if (got.pan != 1'b0) begin
                        check(1'b0, "R8", "panel flag single", 32'(got.pan), 0);
                    end
                    void'(expq.pop_front());
                end
                accepted++;
            end
            if (up_valid && up_ready) begin
                if (cur_d && exp_lower) check(1'b0, "R8", "upper fetched out of turn", 1, 0);
                for (int k = 0; k < count_of(cur_b); k++)
                    expq.push_back(expect_pix(upq[0], cur_b, k, 1'b0));
                total_exp += count_of(cur_b);
                void'(upq.pop_front());
                if (cur_d) exp_lower = 1'b1;
            end
            if (lo_valid && lo_ready) begin
                if (!cur_d || !exp_lower) check(1'b0, "R8", "lower fetched out of turn", 1, 0);
                for (int k = 0; k < count_of(cur_b); k++)
                    expq.push_back(expect_pix(loq[0], cur_b, k, 1'b1));
                total_exp += count_of(cur_b);
                void'(loq.pop_front());
                exp_lower = 1'b0;
            end
            stalled = pix_valid && !pix_ready;
            held = got;
            if (upq.size() == 0 && (loq.size() == 0 || !cur_d) && expq.size() == 0) break;
        end
        check(upq.size() == 0 && expq.size() == 0, "R6", "stream drained",
              32'(upq.size() + expq.size()), 0);
        check(viol_fetch == 0, "R6", "fetch while pixel offered", 32'(viol_fetch), 0);
        check(viol_hold == 0, "R7", "outputs held under backpressure", 32'(viol_hold), 0);
        if (chg_at < 0) begin
            check(accepted == total_exp, "R6", "pixel count", 32'(accepted), 32'(total_exp));
        end
    endtask

    task automatic t_reset_single();
        do_reset(1'b0);
    endtask

    task automatic t_reset_dual();
        do_reset(1'b1);
    endtask

    task automatic t_depths_single();
        run_stream(3'd0, 1'b0, 3, -1, 3'd0, 1'b0, 0, 0, 32'h1357_9BDF); // R1
        run_stream(3'd1, 1'b0, 3, -1, 3'd1, 1'b0, 5, 4, 32'h2468_ACE0); // R2
        run_stream(3'd2, 1'b0, 4, -1, 3'd2, 1'b0, 0, 3, 32'h0F1E_2D3C); // R2
        run_stream(3'd3, 1'b0, 5, -1, 3'd3, 1'b0, 3, 0, 32'hA5A5_5A5A); // R2
        run_stream(3'd4, 1'b0, 6, -1, 3'd4, 1'b0, 4, 3, 32'hF00F_F00F); // R4
        run_stream(3'd5, 1'b0, 6, -1, 3'd5, 1'b0, 0, 5, 32'hC3C3_3C3C); // R3
        run_stream(3'd7, 1'b0, 3, -1, 3'd7, 1'b0, 0, 0, 32'h8421_1248); // R3 code 7
    endtask

    task automatic t_dual_panels();
        run_stream(3'd3, 1'b1, 4, -1, 3'd3, 1'b1, 3, 4, 32'h5EED_0001); // R8
        run_stream(3'd0, 1'b1, 2, -1, 3'd0, 1'b1, 0, 3, 32'h5EED_0002); // R8
        run_stream(3'd4, 1'b1, 3, -1, 3'd4, 1'b1, 5, 0, 32'hFFFF_FFFF); // R4 + R8
    endtask

    task automatic t_mode_change();
        run_stream(3'd3, 1'b0, 3, 2, 3'd5, 1'b0, 0, 0, 32'h0BAD_CAFE);  // R9
        run_stream(3'd2, 1'b1, 3, 9, 3'd1, 1'b1, 0, 0, 32'h1234_5678);  // R9 panel restart
        run_stream(3'd5, 1'b1, 2, 1, 3'd2, 1'b0, 0, 3, 32'h7777_1111);  // R9 dual to single
    endtask

    initial begin
        t_reset_single();
        t_depths_single();
        t_reset_dual();
        t_dual_panels();
        t_mode_change();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule